// File: doc/BRIEF.md
# Two-Region Cache Lookup Front End with Drowsy Slow Region

This block sits in front of a cache level that is split into a small fast region and a large slow region. The two regions hold disjoint lines. For each accepted lookup it starts the tag search in both regions in the same cycle. It then merges the two tag results into one response that carries hit or miss, the region that hit and the number of cycles the lookup took. If the fast region hits while the slow search is still running, that search is aborted.

The slow region's data array is held in a low-power drowsy state by default. It is woken only when it must supply data (a slow-region hit) or take part in a line swap. Waking costs a configurable delay of 1, 4, 8 or 16 cycles, and only the paths that need the slow region pay it. After the slow region has been used, an idle timer returns it to drowsy. The fast region has no power control and is never put to sleep. Two event counters report how many wake-ups and how many aborted slow searches have occurred.

Top module: `region_lookup_front`

## Requirements
- R1: In the cycle after a lookup is accepted, `fastReqValid` and `slowReqValid` are both high for exactly one cycle and both carry the accepted tag. A swap operation (`reqSwap`=1) issues no tag request.
- R2: If the fast tag port reports a hit sampled at edge F after the accept edge, the response arrives at edge F+1 with `rspHit`=1, `rspRegion`=0 (0 = fast, 1 = slow), and `rspLatency` equal to the number of edges from accept to response.
- R3: When a fast hit is reported while the slow search has not yet answered, `slowCancel` is high for one cycle, in the cycle before the response edge, and `cancelCount` increases by one. If the slow search had already answered, no cancel is raised.
- R4: A miss (`rspHit`=0) is reported only after both searches have answered, at edge max(F,S)+1.
- R5: A slow-region hit is answered with `rspRegion`=1 at edge max(F+1, S+1+D), where D is the wake delay if the slow region was drowsy after edge S, and 0 otherwise.
- R6: After reset `slowDrowsy`=1. Fast hits and misses never wake the slow region.
- R7: The wake delay is the parameter `WAKE_CYC`, restricted to 1, 4, 8 or 16. Any other value is an elaboration error.
- R8: The slow region goes drowsy exactly `IDLE_CYC` edges after the response of the last operation that used it. Using it again before then reloads the timer.
- R9: A swap is answered with `rspHit`=1 and `rspRegion`=1, with latency 1 if the slow region is awake and 1+`WAKE_CYC` if it is drowsy.
- R10: At most one operation is outstanding. `reqReady` is low from accept until the response edge.
- R11: `wakeCount` increases by one for each transition from drowsy to waking and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request |
| reqReady | output | 1 | Block can accept an operation |
| reqTag | input | TAG_W | Tag to look up |
| reqSwap | input | 1 | 1 = swap operation, 0 = lookup |
| fastReqValid | output | 1 | Fast tag search start |
| fastReqTag | output | TAG_W | Tag sent to the fast region |
| fastRspValid | input | 1 | Fast tag search result valid |
| fastRspHit | input | 1 | Fast tag search hit |
| slowReqValid | output | 1 | Slow tag search start |
| slowReqTag | output | TAG_W | Tag sent to the slow region |
| slowRspValid | input | 1 | Slow tag search result valid |
| slowRspHit | input | 1 | Slow tag search hit |
| slowCancel | output | 1 | Abort the running slow search |
| slowDrowsy | output | 1 | Slow region not fully awake |
| rspValid | output | 1 | Response pulse |
| rspHit | output | 1 | 1 = hit (or swap done) |
| rspRegion | output | 1 | 0 = fast, 1 = slow |
| rspLatency | output | LAT_W | Edges from accept to response |
| wakeCount | output | CNT_W | Wake-up events |
| cancelCount | output | CNT_W | Aborted slow searches |

## Verification
A power state that is out of step with the idle timer shows up at the next slow hit or swap: the latency is off by exactly the wake delay, and `wakeCount` diverges by one at that same response. A stale per-region result flag shows as a wrong region, a premature miss, or a missing or extra `slowCancel` pulse on the very next lookup. Random spacing between operations places slow hits on both sides of the idle-timer boundary. Directed cases pin the exact cycle at which the region falls asleep.

// File: rtl/lookup_pkg.sv
package lookup_pkg;
  typedef enum logic [1:0] {PWR_DROWSY, PWR_WAKING, PWR_AWAKE} pwr_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic accept;     // operation taken this cycle
    logic issue;      // start tag searches (lookup only)
    logic fire;       // response produced this cycle
    logic cancel;     // abort running slow search
    logic wakeStart;  // slow region leaves drowsy
    logic hitSel;     // response hit value
    logic slowSel;    // response region value
  } strobe_t;
endpackage

// File: rtl/lookup_ctrl.sv
module lookup_ctrl
  import lookup_pkg::*;
#(
  parameter int WAKE_CYC = 4,
  parameter int IDLE_CYC = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqSwap,
  input  logic    fastRspValid,
  input  logic    fastRspHit,
  input  logic    slowRspValid,
  input  logic    slowRspHit,
  output logic    reqReady,
  output logic    slowDrowsy,
  output strobe_t st
);
  localparam int WCW = $clog2(WAKE_CYC + 1);
  localparam int ICW = $clog2(IDLE_CYC + 1);

  generate
    if (!(WAKE_CYC == 1 || WAKE_CYC == 4 || WAKE_CYC == 8 || WAKE_CYC == 16)) begin : g_badWake
      $error("WAKE_CYC must be 1, 4, 8 or 16");
    end
  endgenerate

  logic busy, swapR, fDone, fHit, sDone, sHit;
  pwr_e pwr;
  logic [WCW-1:0] wakeCnt;
  logic [ICW-1:0] idleCnt;
  logic slowDemand, slowReadyNow, fire;

  assign reqReady     = !busy;
  assign slowDrowsy   = (pwr != PWR_AWAKE);
  assign slowDemand   = busy && (swapR || (sDone && sHit));
  assign slowReadyNow = (pwr == PWR_AWAKE) || (pwr == PWR_WAKING && wakeCnt == WCW'(1));

  always_comb begin
    if (!busy)      fire = 1'b0;
    else if (swapR) fire = slowReadyNow;
    else            fire = fDone && (fHit || (sDone && (!sHit || slowReadyNow)));
  end

  always_comb begin
    st.accept    = reqValid && !busy;
    st.issue     = reqValid && !busy && !reqSwap;
    st.fire      = fire;
    st.cancel    = fire && !swapR && fHit && !sDone;
    st.wakeStart = slowDemand && (pwr == PWR_DROWSY);
    st.hitSel    = swapR || fHit || sHit;
    st.slowSel   = swapR || (!fHit && sHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; swapR <= 1'b0;
      fDone <= 1'b0; fHit <= 1'b0; sDone <= 1'b0; sHit <= 1'b0;
    end else if (st.accept) begin
      busy <= 1'b1; swapR <= reqSwap;
      fDone <= 1'b0; fHit <= 1'b0; sDone <= 1'b0; sHit <= 1'b0;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy && !swapR) begin
      if (fastRspValid && !fDone) begin fDone <= 1'b1; fHit <= fastRspHit; end
      if (slowRspValid && !sDone) begin sDone <= 1'b1; sHit <= slowRspHit; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwr <= PWR_DROWSY; wakeCnt <= '0; idleCnt <= '0;
    end else begin
      case (pwr)
        PWR_DROWSY: if (st.wakeStart) begin
          pwr <= PWR_WAKING; wakeCnt <= WCW'(WAKE_CYC);
        end
        PWR_WAKING: if (wakeCnt == WCW'(1)) begin
          pwr <= PWR_AWAKE; idleCnt <= ICW'(IDLE_CYC);
        end else begin
          wakeCnt <= wakeCnt - WCW'(1);
        end
        default: if (slowDemand) idleCnt <= ICW'(IDLE_CYC);
        else if (idleCnt == ICW'(1)) pwr <= PWR_DROWSY;
        else idleCnt <= idleCnt - ICW'(1);
      endcase
    end
  end

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_wake_bounds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pwr == PWR_WAKING) |-> (wakeCnt >= WCW'(1) && wakeCnt <= WCW'(WAKE_CYC)));
  p_demand_keeps_awake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pwr == PWR_AWAKE && slowDemand) |=> (pwr == PWR_AWAKE));
  p_no_spurious_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pwr == PWR_DROWSY && !slowDemand) |=> (pwr == PWR_DROWSY));
endmodule

// File: rtl/lookup_dp.sv
module lookup_dp
  import lookup_pkg::*;
#(
  parameter int TAG_W = 12,
  parameter int LAT_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [TAG_W-1:0] reqTag,
  output logic             issueValid,
  output logic [TAG_W-1:0] issueTag,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspRegion,
  output logic [LAT_W-1:0] rspLatency,
  output logic [CNT_W-1:0] wakeCount,
  output logic [CNT_W-1:0] cancelCount
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;
  logic [LAT_W-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueValid <= 1'b0; issueTag <= '0; latCnt <= '0;
      rspValid <= 1'b0; rspHit <= 1'b0; rspRegion <= 1'b0; rspLatency <= '0;
      wakeCount <= '0; cancelCount <= '0;
    end else begin
      issueValid <= st.issue;
      if (st.accept) issueTag <= reqTag;
      if (st.accept) latCnt <= '0;
      else if (latCnt != LAT_MAX) latCnt <= latCnt + LAT_W'(1);
      rspValid <= st.fire;
      if (st.fire) begin
        rspHit     <= st.hitSel;
        rspRegion  <= st.slowSel;
        rspLatency <= (latCnt == LAT_MAX) ? latCnt : latCnt + LAT_W'(1);
      end
      if (st.wakeStart) wakeCount <= wakeCount + CNT_W'(1);
      if (st.cancel) cancelCount <= cancelCount + CNT_W'(1);
    end
  end

  p_cancel_fast_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.cancel |=> (rspValid && rspHit && !rspRegion));
  p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_wake_count_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !st.wakeStart |=> $stable(wakeCount));
  p_issue_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);
endmodule

// File: rtl/region_lookup_front.sv
module region_lookup_front
  import lookup_pkg::*;
#(
  parameter int TAG_W    = 12,
  parameter int LAT_W    = 6,
  parameter int CNT_W    = 16,
  parameter int WAKE_CYC = 4,
  parameter int IDLE_CYC = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             reqSwap,
  output logic             fastReqValid,
  output logic [TAG_W-1:0] fastReqTag,
  input  logic             fastRspValid,
  input  logic             fastRspHit,
  output logic             slowReqValid,
  output logic [TAG_W-1:0] slowReqTag,
  input  logic             slowRspValid,
  input  logic             slowRspHit,
  output logic             slowCancel,
  output logic             slowDrowsy,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspRegion,
  output logic [LAT_W-1:0] rspLatency,
  output logic [CNT_W-1:0] wakeCount,
  output logic [CNT_W-1:0] cancelCount
);
  strobe_t st;
  logic issueValid;
  logic [TAG_W-1:0] issueTag;

  lookup_ctrl #(.WAKE_CYC(WAKE_CYC), .IDLE_CYC(IDLE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSwap(reqSwap),
    .fastRspValid(fastRspValid), .fastRspHit(fastRspHit),
    .slowRspValid(slowRspValid), .slowRspHit(slowRspHit),
    .reqReady(reqReady), .slowDrowsy(slowDrowsy), .st(st));

  lookup_dp #(.TAG_W(TAG_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .reqTag(reqTag),
    .issueValid(issueValid), .issueTag(issueTag),
    .rspValid(rspValid), .rspHit(rspHit), .rspRegion(rspRegion),
    .rspLatency(rspLatency), .wakeCount(wakeCount), .cancelCount(cancelCount));

  assign fastReqValid = issueValid;
  assign slowReqValid = issueValid;
  assign fastReqTag   = issueTag;
  assign slowReqTag   = issueTag;
  assign slowCancel   = st.cancel;
endmodule

// File: tb/sim_region_lookup_front.sv
module sim_region_lookup_front;
  localparam int TAG_W = 12, LAT_W = 6, CNT_W = 16, W = 4, IDLE = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqSwap = 1'b0, fastRspValid = 1'b0, fastRspHit = 1'b0;
  logic slowRspValid = 1'b0, slowRspHit = 1'b0;
  logic [TAG_W-1:0] reqTag = '0;
  logic reqReady, fastReqValid, slowReqValid, slowCancel, slowDrowsy;
  logic rspValid, rspHit, rspRegion;
  logic [TAG_W-1:0] fastReqTag, slowReqTag;
  logic [LAT_W-1:0] rspLatency;
  logic [CNT_W-1:0] wakeCount, cancelCount;

  region_lookup_front #(.TAG_W(TAG_W), .LAT_W(LAT_W), .CNT_W(CNT_W),
    .WAKE_CYC(W), .IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqTag(reqTag),
    .reqSwap(reqSwap), .fastReqValid(fastReqValid), .fastReqTag(fastReqTag),
    .fastRspValid(fastRspValid), .fastRspHit(fastRspHit), .slowReqValid(slowReqValid),
    .slowReqTag(slowReqTag), .slowRspValid(slowRspValid), .slowRspHit(slowRspHit),
    .slowCancel(slowCancel), .slowDrowsy(slowDrowsy), .rspValid(rspValid), .rspHit(rspHit),
    .rspRegion(rspRegion), .rspLatency(rspLatency), .wakeCount(wakeCount),
    .cancelCount(cancelCount));

  always #10ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;
  int lastUse = -1000, expWakes = 0, expCancels = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit drowsyAt(input int e);
    return !(e < lastUse + IDLE);
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic idleGap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // common tail: response fields, counters and power state after response
  task automatic checkRsp(input string req, input int e0, input int expLat, input bit expHit,
                          input bit expRegion, input bit usedSlow);
    chk({req, " latency"}, int'(rspLatency), expLat);
    chk({req, " response edge"}, cyc - e0, expLat);
    chk({req, " hit"}, int'(rspHit), int'(expHit));
    chk({req, " region"}, int'(rspRegion), int'(expRegion));
    if (usedSlow) lastUse = cyc;
    chk("R6/R8 drowsy after response", int'(slowDrowsy), int'(drowsyAt(cyc)));
    chk("R11 wakeCount", int'(wakeCount), expWakes);
    chk("R3 cancelCount", int'(cancelCount), expCancels);
    chk("R10 ready after response", int'(reqReady), 1);
  endtask

  // lookup with fast result at edge fd and slow result at edge sd after accept
  task automatic doLookup(input int fd, input int sd, input bit fh, input bit sh);
    int e0, expLat;
    bit got, sawCancel, expCancel, wake;
    logic [TAG_W-1:0] tag;
    tag = TAG_W'($urandom);
    reqValid = 1'b1; reqSwap = 1'b0; reqTag = tag;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    e0 = cyc;
    chk("R1 fast request", int'(fastReqValid), 1);
    chk("R1 slow request", int'(slowReqValid), 1);
    chk("R1 fast tag", int'(fastReqTag), int'(tag));
    chk("R1 slow tag", int'(slowReqTag), int'(tag));
    chk("R10 busy", int'(reqReady), 0);
    expCancel = fh && (sd > fd);
    wake = 1'b0;
    if (fh) expLat = fd + 1;
    else if (sh) begin
      wake = drowsyAt(e0 + sd);
      expLat = maxi(fd + 1, sd + 1 + (wake ? W : 0));
    end else expLat = maxi(fd, sd) + 1;
    got = 1'b0; sawCancel = 1'b0;
    for (int k = 1; k <= 60 && !got; k++) begin
      if (slowCancel) sawCancel = 1'b1;
      fastRspValid = (k == fd); fastRspHit = fh;
      slowRspValid = (k == sd) && !sawCancel; slowRspHit = sh;
      @(posedge clk); @(negedge clk);
      fastRspValid = 1'b0; slowRspValid = 1'b0;
      if (k == 1) chk("R1 request pulse", int'(fastReqValid), 0);
      if (rspValid) got = 1'b1;
    end
    chk("R2/R4/R5 response seen", int'(got), 1);
    chk("R3 cancel pulse", int'(sawCancel), int'(expCancel));
    if (expCancel) expCancels++;
    if (wake) expWakes++;
    checkRsp(fh ? "R2 fast hit" : (sh ? "R5 slow hit" : "R4 miss"), e0, expLat, fh || sh, !fh && sh, sh);
  endtask

  task automatic doSwap();
    int e0, expLat;
    bit got, wake;
    reqValid = 1'b1; reqSwap = 1'b1; reqTag = TAG_W'($urandom);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; reqSwap = 1'b0;
    e0 = cyc;
    chk("R1 swap issues no search", int'(fastReqValid), 0);
    wake = drowsyAt(e0);
    expLat = 1 + (wake ? W : 0);
    got = rspValid;
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      if (rspValid) got = 1'b1;
    end
    chk("R9 swap response seen", int'(got), 1);
    if (wake) expWakes++;
    checkRsp("R9 swap", e0, expLat, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6 reset drowsy", int'(slowDrowsy), 1);
    chk("R10 reset ready", int'(reqReady), 1);
    chk("R2 reset rspValid", int'(rspValid), 0);
    chk("R11 reset wakeCount", int'(wakeCount), 0);
    chk("R3 reset cancelCount", int'(cancelCount), 0);
    chk("R1 reset no request", int'(fastReqValid), 0);

    // directed corners
    doLookup(1, 5, 1'b1, 1'b0);   // R3 cancel of running slow search
    doLookup(3, 2, 1'b1, 1'b0);   // R3 slow finished first: no cancel
    doLookup(2, 6, 1'b0, 1'b0);   // R4 miss waits for slow
    doLookup(1, 2, 1'b0, 1'b1);   // R5/R7 slow hit from drowsy
    doLookup(2, 1, 1'b0, 1'b1);   // R5 slow hit while awake
    // R8 exact idle boundary
    idleGap(IDLE - 1);
    chk("R8 still awake before timeout", int'(slowDrowsy), 0);
    @(negedge clk);
    chk("R8 drowsy at timeout", int'(slowDrowsy), 1);
    doSwap();                     // R9 drowsy swap
    doSwap();                     // R9 awake swap
    doLookup(7, 1, 1'b0, 1'b0);   // R4 fast answer last
    doLookup(3, 1, 1'b0, 1'b1);   // R5 fast miss late while waking

    // constrained random mix
    for (int n = 0; n < 200; n++) begin
      int sel;
      idleGap($urandom_range(0, 12));
      sel = $urandom_range(0, 99);
      if (sel < 15) doSwap();
      else if (sel < 50) doLookup($urandom_range(1, 3), $urandom_range(1, 8), 1'b1, 1'b0);
      else if (sel < 80) doLookup($urandom_range(1, 3), $urandom_range(1, 8), 1'b0, 1'b1);
      else doLookup($urandom_range(1, 3), $urandom_range(1, 8), 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule